// File: doc/BRIEF.md
# Bus Write Transmitter with Acknowledge Queue

The block feeds a single on-chip bus write port from two sources. One is a queue of short acknowledge and negative-acknowledge messages, each raised by a one-cycle request pulse that comes with a target address. The other is a stream of receive-data words, pulled from an upstream show-ahead FIFO after the upstream controller issues a send request. The send request carries a destination address and an 11-bit length value.

Every message on the bus opens with an address word, written with the address-valid strobe high. A fresh message then carries a formatted header word. Queued acknowledges take precedence over stream data at word boundaries. A stream cut short this way picks up again by writing only its destination address before its next data words, with no second header. All writes obey the bus full signal. A stream stays open and keeps forwarding upstream words until a later send request replaces it.

Top module: `pkt_bus_tx`

## Requirements
- R1: After reset, bus_we_o, bus_av_o and src_re_o are low and tx_ready_o is high.
- R2: An acknowledge message is two consecutive bus writes. The first is the request's address with bus_av_o high. The second is a header with bus_av_o low. The header has its code in bits [31:28]: 4'h1 for acknowledge, 4'h2 for negative acknowledge. Bit 27 is 1 for the transmit kinds and 0 for the receive kinds. All other bits are zero.
- R3: A send request is taken only in a cycle where tx_ready_o is high, and tx_ready_o is low in the cycle after one is taken. It goes high again once the stream's address and header are written and the stream is not interrupted. A request while tx_ready_o is low has no effect.
- R4: A taken send request produces its destination address with bus_av_o high. Next comes a header with code 4'h3 in bits [31:28], the length value in bits [27:17], and zeros elsewhere.
- R5: Stream data words are read with src_re_o only while src_empty_i is low. They are written in order and unchanged, with bus_av_o low.
- R6: A write completes in a cycle with bus_we_o high and bus_full_i low. While bus_full_i holds a pending write back, bus_data_o and bus_av_o stay unchanged.
- R7: A queued acknowledge is sent before any further stream word at the next word boundary. It is never placed between a stream address and its header.
- R8: After an acknowledge interrupts a stream, the stream continues with its destination address (bus_av_o high) and no header, then its remaining data.
- R9: The acknowledge queue holds ACK_DEPTH requests (5 by default), sent in arrival order. If several request pulses arrive in one cycle, only one is kept, chosen in the order tx ack, tx nack, rx ack, rx nack.
- R10: bus_cmd_o equals WR_CMD (5'h02) whenever bus_we_o is high and is zero otherwise, and bus_av_o is never high without bus_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_tx_i | input | 1 | Pulse: queue a transmit acknowledge |
| nack_tx_i | input | 1 | Pulse: queue a transmit negative acknowledge |
| ack_rx_i | input | 1 | Pulse: queue a receive acknowledge |
| nack_rx_i | input | 1 | Pulse: queue a receive negative acknowledge |
| ack_addr_i | input | 32 | Target address for the request pulse |
| send_req_i | input | 1 | Start a new data stream |
| send_len_i | input | 11 | Length value copied into the stream header |
| send_addr_i | input | 32 | Stream destination address |
| tx_ready_o | output | 1 | New send request may be issued |
| src_empty_i | input | 1 | Upstream FIFO has no word |
| src_data_i | input | 32 | Upstream FIFO head word |
| src_re_o | output | 1 | Pop the upstream FIFO head |
| bus_cmd_o | output | 5 | Bus command |
| bus_data_o | output | 32 | Bus address or data word |
| bus_av_o | output | 1 | Word is an address |
| bus_we_o | output | 1 | Write request |
| bus_full_i | input | 1 | Bus cannot take a write this cycle |

## Verification
The bench goes after the boundaries where the two traffic kinds meet. It raises an acknowledge while a stream is stalled and again while words flow under an irregular full pattern. A design that lost the resume address, or repeated the header, would leave data words without a destination or carrying a stray header. It fills the queue to its depth while the bus is held full, so an off-by-one queue drops the last request. It also issues a send request while tx_ready_o is low and raises same-cycle request pulses, so a design that accepted either would write an extra message or the wrong address and length.

// File: rtl/pkt_bus_tx_pkg.sv
package pkt_bus_tx_pkg;
  localparam int unsigned MSG_ID_W = 4;

  typedef enum logic [MSG_ID_W-1:0] {
    ID_ACK  = 4'h1,
    ID_NACK = 4'h2,
    ID_DATA = 4'h3
  } msg_id_e;

  typedef enum logic [1:0] {
    PH_FREE,
    PH_ACK_HDR,
    PH_DATA_HDR
  } phase_e;
endpackage

// File: rtl/ptx_rst_sync.sv
module ptx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ptx_ack_fifo.sv
module ptx_ack_fifo #(
  parameter int unsigned W     = 34,
  parameter int unsigned DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  assign dout_o  = mem[rd_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/ptx_hdr_fmt.sv
module ptx_hdr_fmt
  import pkt_bus_tx_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 11
) (
  input  msg_id_e          id_i,
  input  logic             tx_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DW-1:0]    word_o
);
  localparam int unsigned BELOW = DW - MSG_ID_W;

  always_comb begin
    word_o = '0;
    word_o[DW-1 -: MSG_ID_W] = id_i;
    if (id_i == ID_DATA) word_o[BELOW-1 -: LEN_W] = len_i;
    else                 word_o[BELOW-1]          = tx_i;
  end
endmodule

// File: rtl/pkt_bus_tx.sv
module pkt_bus_tx
  import pkt_bus_tx_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       LEN_W     = 11,
  parameter int unsigned       CMD_W     = 5,
  parameter int unsigned       ACK_DEPTH = 5,
  parameter logic [CMD_W-1:0]  WR_CMD    = 5'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_tx_i,
  input  logic              nack_tx_i,
  input  logic              ack_rx_i,
  input  logic              nack_rx_i,
  input  logic [DATA_W-1:0] ack_addr_i,
  input  logic              send_req_i,
  input  logic [LEN_W-1:0]  send_len_i,
  input  logic [DATA_W-1:0] send_addr_i,
  output logic              tx_ready_o,
  input  logic              src_empty_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_re_o,
  output logic [CMD_W-1:0]  bus_cmd_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_av_o,
  output logic              bus_we_o,
  input  logic              bus_full_i
);
  typedef struct packed {
    logic              nack;
    logic              tx;
    logic [DATA_W-1:0] addr;
  } ack_ent_t;

  localparam int unsigned ENT_W = $bits(ack_ent_t);

  logic rst_ns;
  ptx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  // Request encoding: one entry per cycle, fixed priority
  ack_ent_t push_ent, q_ent;
  logic     push, pop, q_empty;
  logic [ENT_W-1:0] q_raw;

  always_comb begin
    push          = ack_tx_i | nack_tx_i | ack_rx_i | nack_rx_i;
    push_ent.addr = ack_addr_i;
    push_ent.tx   = ack_tx_i | nack_tx_i;
    push_ent.nack = ack_tx_i ? 1'b0 : nack_tx_i ? 1'b1 : ack_rx_i ? 1'b0 : 1'b1;
  end

  ptx_ack_fifo #(.W(ENT_W), .DEPTH(ACK_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_ns),
    .push_i(push), .din_i(push_ent), .pop_i(pop),
    .dout_o(q_raw), .empty_o(q_empty)
  );
  assign q_ent = ack_ent_t'(q_raw);

  // State
  phase_e            phase_q, phase_d;
  logic              pend_nack_q, pend_nack_d, pend_tx_q, pend_tx_d;
  logic              strm_act_q, strm_act_d, strm_new_q, strm_new_d;
  logic              on_strm_q, on_strm_d;
  logic [DATA_W-1:0] strm_addr_q, strm_addr_d;
  logic [LEN_W-1:0]  strm_len_q, strm_len_d;
  logic              out_we_q, out_we_d, out_av_q, out_av_d;
  logic [DATA_W-1:0] out_data_q, out_data_d;

  logic              load_ok, accept, re;
  msg_id_e           hdr_id;
  logic [DATA_W-1:0] hdr_word;

  assign hdr_id = (phase_q == PH_DATA_HDR) ? ID_DATA : (pend_nack_q ? ID_NACK : ID_ACK);

  ptx_hdr_fmt #(.DW(DATA_W), .LEN_W(LEN_W)) u_hdr (
    .id_i(hdr_id), .tx_i(pend_tx_q), .len_i(strm_len_q), .word_o(hdr_word)
  );

  assign tx_ready_o = !strm_new_q && (!strm_act_q || on_strm_q);
  assign load_ok    = !out_we_q || !bus_full_i;
  assign accept     = send_req_i && tx_ready_o;

  always_comb begin
    phase_d     = phase_q;
    pend_nack_d = pend_nack_q;
    pend_tx_d   = pend_tx_q;
    strm_act_d  = strm_act_q;
    strm_new_d  = strm_new_q;
    on_strm_d   = on_strm_q;
    strm_addr_d = strm_addr_q;
    strm_len_d  = strm_len_q;
    out_we_d    = out_we_q;
    out_av_d    = out_av_q;
    out_data_d  = out_data_q;
    pop         = 1'b0;
    re          = 1'b0;
    if (load_ok) begin
      out_we_d   = 1'b0;
      out_av_d   = 1'b0;
      out_data_d = '0;
      if (phase_q == PH_ACK_HDR) begin
        out_we_d   = 1'b1;
        out_data_d = hdr_word;
        phase_d    = PH_FREE;
      end else if (phase_q == PH_DATA_HDR) begin
        out_we_d   = 1'b1;
        out_data_d = hdr_word;
        phase_d    = PH_FREE;
        strm_new_d = 1'b0;
      end else if (!q_empty) begin
        out_we_d    = 1'b1;
        out_av_d    = 1'b1;
        out_data_d  = q_ent.addr;
        pop         = 1'b1;
        pend_nack_d = q_ent.nack;
        pend_tx_d   = q_ent.tx;
        phase_d     = PH_ACK_HDR;
        on_strm_d   = 1'b0;
      end else if (strm_act_q && !on_strm_q) begin
        out_we_d   = 1'b1;
        out_av_d   = 1'b1;
        out_data_d = strm_addr_q;
        on_strm_d  = 1'b1;
        if (strm_new_q) phase_d = PH_DATA_HDR;
      end else if (strm_act_q && !src_empty_i) begin
        re         = 1'b1;
        out_we_d   = 1'b1;
        out_data_d = src_data_i;
      end
    end
    if (accept) begin
      strm_addr_d = send_addr_i;
      strm_len_d  = send_len_i;
      strm_act_d  = 1'b1;
      strm_new_d  = 1'b1;
      on_strm_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q     <= PH_FREE;
      pend_nack_q <= 1'b0;
      pend_tx_q   <= 1'b0;
      strm_act_q  <= 1'b0;
      strm_new_q  <= 1'b0;
      on_strm_q   <= 1'b0;
      strm_addr_q <= '0;
      strm_len_q  <= '0;
      out_we_q    <= 1'b0;
      out_av_q    <= 1'b0;
      out_data_q  <= '0;
    end else begin
      phase_q     <= phase_d;
      pend_nack_q <= pend_nack_d;
      pend_tx_q   <= pend_tx_d;
      strm_act_q  <= strm_act_d;
      strm_new_q  <= strm_new_d;
      on_strm_q   <= on_strm_d;
      if (accept) begin
        strm_addr_q <= strm_addr_d;
        strm_len_q  <= strm_len_d;
      end
      if (load_ok) begin
        out_we_q   <= out_we_d;
        out_av_q   <= out_av_d;
        out_data_q <= out_data_d;
      end
    end
  end

  assign src_re_o   = re;
  assign bus_we_o   = out_we_q;
  assign bus_av_o   = out_av_q;
  assign bus_data_o = out_data_q;
  assign bus_cmd_o  = out_we_q ? WR_CMD : '0;
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
  parameter int unsigned      DW     = 32,
  parameter int unsigned      CW     = 5,
  parameter logic [CW-1:0]    WR_CMD = 5'h02
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we_o,
  input logic          bus_av_o,
  input logic          bus_full_i,
  input logic [DW-1:0] bus_data_o,
  input logic [CW-1:0] bus_cmd_o,
  input logic          src_re_o,
  input logic          src_empty_i,
  input logic          send_req_i,
  input logic          tx_ready_o
);
  p_hold_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_o && bus_full_i |=> bus_we_o && $stable(bus_data_o) && $stable(bus_av_o));

  p_read_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_re_o |-> !src_empty_i);

  p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_req_i && tx_ready_o |=> !tx_ready_o);

  p_av_needs_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_av_o |-> bus_we_o);

  p_cmd_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_o |-> bus_cmd_o == WR_CMD);

  p_cmd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_o |-> bus_cmd_o == '0);
endmodule

bind pkt_bus_tx ptx_checker #(.DW(DATA_W), .CW(CMD_W), .WR_CMD(WR_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_we_o(bus_we_o), .bus_av_o(bus_av_o), .bus_full_i(bus_full_i),
  .bus_data_o(bus_data_o), .bus_cmd_o(bus_cmd_o),
  .src_re_o(src_re_o), .src_empty_i(src_empty_i),
  .send_req_i(send_req_i), .tx_ready_o(tx_ready_o)
);

// File: tb/tb_pkt_bus_tx.sv
`timescale 1ns/1ps
module tb_pkt_bus_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_tx = 0, nack_tx = 0, ack_rx = 0, nack_rx = 0;
  logic [31:0] ack_addr = '0;
  logic        send_req = 0;
  logic [10:0] send_len = '0;
  logic [31:0] send_addr = '0;
  logic        tx_ready, src_empty, src_re, bus_av, bus_we, bus_full;
  logic [31:0] src_data, bus_data;
  logic [4:0]  bus_cmd;

  logic        full_force = 0, full_pat = 0, fpat_bit = 0;
  int          fcnt = 0;
  logic [31:0] mem [0:1023];
  int          src_wr = 0, src_rd = 0, gidx = 0;
  logic        src_stall = 0;
  logic [31:0] cap_data [0:2047];
  logic        cap_av   [0:2047];
  int          cap_n = 0;
  logic        cmd_bad = 0, av_bad = 0;
  int          n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign bus_full  = full_force || (full_pat && fpat_bit);
  assign src_empty = (src_rd == src_wr) || src_stall;
  assign src_data  = mem[src_rd % 1024];

  pkt_bus_tx dut (
    .clk(clk), .rst_n(rst_n),
    .ack_tx_i(ack_tx), .nack_tx_i(nack_tx), .ack_rx_i(ack_rx), .nack_rx_i(nack_rx),
    .ack_addr_i(ack_addr),
    .send_req_i(send_req), .send_len_i(send_len), .send_addr_i(send_addr),
    .tx_ready_o(tx_ready),
    .src_empty_i(src_empty), .src_data_i(src_data), .src_re_o(src_re),
    .bus_cmd_o(bus_cmd), .bus_data_o(bus_data), .bus_av_o(bus_av), .bus_we_o(bus_we),
    .bus_full_i(bus_full)
  );

  always @(negedge clk) begin
    fcnt     <= fcnt + 1;
    fpat_bit <= ((fcnt % 7) == 2) || ((fcnt % 7) == 3) || ((fcnt % 11) == 5);
  end

  always @(posedge clk) begin
    if (src_re) src_rd <= src_rd + 1;
    if (bus_we && !bus_full) begin
      cap_data[cap_n] = bus_data;
      cap_av[cap_n]   = bus_av;
      cap_n           = cap_n + 1;
    end
    if (bus_we && bus_cmd != 5'h02) cmd_bad = 1'b1;
    if (!bus_we && bus_cmd != 5'h00) cmd_bad = 1'b1;
    if (bus_av && !bus_we) av_bad = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input int idx, input logic [31:0] d, input logic av, input string req);
    if (idx >= cap_n) chk(0, req, 32'hFFFF_FFFF, d);
    else chk(cap_data[idx] == d && cap_av[idx] == av, req, cap_data[idx], d);
  endtask

  function automatic logic [31:0] ack_hdr(input logic nack, input logic tx);
    return {(nack ? 4'h2 : 4'h1), tx, 27'b0};
  endfunction

  function automatic logic [31:0] data_hdr(input logic [10:0] len);
    return {4'h3, len, 17'b0};
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 tx ack, 1 tx nack, 2 rx ack, 3 rx nack
  task automatic pulse_req(input int kind, input logic [31:0] a);
    @(negedge clk);
    ack_tx = (kind == 0); nack_tx = (kind == 1);
    ack_rx = (kind == 2); nack_rx = (kind == 3);
    ack_addr = a;
    @(negedge clk);
    ack_tx = 0; nack_tx = 0; ack_rx = 0; nack_rx = 0;
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      mem[src_wr % 1024] = 32'hD000_0000 + gidx;
      gidx++;
      src_wr++;
    end
  endtask

  task automatic t_reset;
    chk(!bus_we && !bus_av && !src_re && tx_ready, "R1 reset outputs",
        {28'b0, bus_we, bus_av, src_re, tx_ready}, 32'h1);
  endtask

  task automatic t_ack_pair;
    int base = cap_n;
    pulse_req(0, 32'hA000_0001);
    ack_tx = 0; ack_addr = 32'hA000_0002; nack_rx = 1;
    @(negedge clk); nack_rx = 0;
    wait_n(12);
    expect_word(base,   32'hA000_0001, 1, "R2 tx ack address");
    expect_word(base+1, ack_hdr(0, 1), 0, "R2 tx ack header");
    expect_word(base+2, 32'hA000_0002, 1, "R9 back-to-back rx nack address");
    expect_word(base+3, ack_hdr(1, 0), 0, "R2 rx nack header");
    chk(cap_n - base == 4, "R2 word count", cap_n - base, 4);
  endtask

  task automatic t_simul;
    int base = cap_n;
    @(negedge clk);
    nack_tx = 1; ack_rx = 1; ack_addr = 32'hA000_0003;
    @(negedge clk);
    nack_tx = 0; ack_rx = 0;
    wait_n(10);
    expect_word(base,   32'hA000_0003, 1, "R9 same-cycle address");
    expect_word(base+1, ack_hdr(1, 1), 0, "R9 same-cycle priority header");
    chk(cap_n - base == 2, "R9 same-cycle single message", cap_n - base, 2);
  endtask

  task automatic t_queue_depth;
    int base = cap_n;
    @(negedge clk); full_force = 1;
    for (int k = 0; k < 6; k++) begin
      ack_tx = (k % 4 == 0); nack_tx = (k % 4 == 1);
      ack_rx = (k % 4 == 2); nack_rx = (k % 4 == 3);
      ack_addr = 32'hB000_0000 + k;
      @(negedge clk);
    end
    ack_tx = 0; nack_tx = 0; ack_rx = 0; nack_rx = 0;
    wait_n(3); full_force = 0;
    wait_n(25);
    for (int k = 0; k < 6; k++) begin
      expect_word(base + 2*k, 32'hB000_0000 + k, 1, "R9 queued address in order");
      expect_word(base + 2*k + 1, ack_hdr(k % 2 == 1, k % 4 < 2), 0, "R9 queued header");
    end
  endtask

  task automatic t_stream_basic;
    int base = cap_n;
    int first = gidx;
    chk(tx_ready, "R3 ready before request", tx_ready, 1);
    @(negedge clk);
    send_req = 1; send_addr = 32'hC000_0010; send_len = 11'h155;
    @(negedge clk);
    send_req = 0;
    chk(!tx_ready, "R3 ready low after accept", tx_ready, 0);
    push_words(4);
    wait_n(15);
    expect_word(base,   32'hC000_0010, 1, "R4 stream address");
    expect_word(base+1, data_hdr(11'h155), 0, "R4 stream header");
    for (int k = 0; k < 4; k++)
      expect_word(base + 2 + k, 32'hD000_0000 + first + k, 0, "R5 data word in order");
    chk(tx_ready, "R3 ready back after header", tx_ready, 1);
  endtask

  task automatic t_ignore_busy;
    int base = cap_n;
    int first;
    @(negedge clk); full_force = 1;
    send_req = 1; send_addr = 32'hC000_0020; send_len = 11'h00A;
    @(negedge clk); send_req = 0;
    chk(!tx_ready, "R3 ready low while setup pending", tx_ready, 0);
    send_req = 1; send_addr = 32'hC000_0030; send_len = 11'h7FF;
    @(negedge clk); send_req = 0;
    wait_n(2); full_force = 0;
    first = gidx;
    push_words(2);
    wait_n(12);
    expect_word(base,   32'hC000_0020, 1, "R3 busy request ignored, first address kept");
    expect_word(base+1, data_hdr(11'h00A), 0, "R3 busy request ignored, first length kept");
    expect_word(base+2, 32'hD000_0000 + first, 0, "R5 data after header");
    expect_word(base+3, 32'hD000_0000 + first + 1, 0, "R5 second data");
    chk(cap_n - base == 4, "R3 no extra message", cap_n - base, 4);
  endtask

  task automatic t_flow_full;
    int base = cap_n;
    int first = gidx;
    bit ok = 1;
    full_pat = 1;
    push_words(24);
    wait_n(120);
    full_pat = 0;
    wait_n(4);
    for (int k = 0; k < 24; k++)
      if (cap_data[base+k] !== 32'hD000_0000 + first + k || cap_av[base+k] !== 1'b0) ok = 0;
    chk(ok && cap_n - base == 24, "R6 data intact under full pattern", cap_n - base, 24);
    chk(src_rd == src_wr, "R5 all upstream words read", src_rd, src_wr);
  endtask

  task automatic t_preempt_idle;
    int base = cap_n;
    int first = gidx;
    src_stall = 1;
    push_words(3);
    pulse_req(2, 32'hE000_0001);
    wait_n(8);
    src_stall = 0;
    wait_n(12);
    expect_word(base,   32'hE000_0001, 1, "R7 ack before data");
    expect_word(base+1, ack_hdr(0, 0), 0, "R2 rx ack header");
    expect_word(base+2, 32'hC000_0020, 1, "R8 resume address");
    expect_word(base+3, 32'hD000_0000 + first, 0, "R8 no header on resume");
    expect_word(base+5, 32'hD000_0000 + first + 2, 0, "R8 last resumed word");
  endtask

  task automatic t_preempt_flow;
    int base = cap_n;
    int first = gidx;
    int k_ack = -1;
    int nxt;
    bit ok = 1;
    push_words(30);
    full_pat = 1;
    wait_n(6);
    pulse_req(1, 32'hE000_0002);
    wait_n(150);
    full_pat = 0;
    wait_n(4);
    for (int i = base; i < cap_n; i++)
      if (cap_av[i] && cap_data[i] == 32'hE000_0002 && k_ack < 0) k_ack = i;
    chk(k_ack >= 0, "R7 nack sent during stream", k_ack, base);
    if (k_ack >= 0) begin
      expect_word(k_ack+1, ack_hdr(1, 1), 0, "R7 nack header follows address");
      expect_word(k_ack+2, 32'hC000_0020, 1, "R8 resume address after nack");
      chk(cap_data[k_ack+3][31:28] == 4'hD && !cap_av[k_ack+3], "R8 data, not header, after resume",
          cap_data[k_ack+3], 32'hD000_0000);
    end
    nxt = first;
    for (int i = base; i < cap_n; i++) begin
      if (i >= k_ack && i <= k_ack + 2) continue;
      if (cap_av[i] || cap_data[i] != 32'hD000_0000 + nxt) ok = 0;
      nxt++;
    end
    chk(ok && nxt == first + 30, "R5 order kept across interruption", nxt - first, 30);
    chk(tx_ready, "R3 ready after resume", tx_ready, 1);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_ack_pair();
    t_simul();
    t_queue_depth();
    t_stream_basic();
    t_ignore_busy();
    t_flow_full();
    t_preempt_idle();
    t_preempt_flow();
    chk(!cmd_bad, "R10 command field", {31'b0, cmd_bad}, 0);
    chk(!av_bad, "R10 address strobe without write", {31'b0, av_bad}, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule